// File: doc/BRIEF.md
# Indexed RTC Register Port

This block is the host-facing register front end of a real-time clock. The host reaches every register in two steps. It first writes a register number to the address port. It then reads or writes the selected byte through the data port. The number stays latched, so one index can serve any count of data accesses. Time and alarm bytes live in an external counter block, which this port reaches over a small shared bus. The control registers, the interrupt flag register and 50 bytes of general-purpose storage are held here.

Indexes 0 to 9 pass through to the timekeeping counters. Index 10 is the divider/rate register, which carries a read-only update-in-progress bit. Index 11 is the mode/enable register. Index 12 is the interrupt flag register, which the host can only read and which clears itself on a data read. Index 13 is the status register, which carries a battery-good bit taken from a pin. Indexes 14 to 63 are general storage. Interrupt sources pulse one-cycle strobes into the flag register. Each flag is then gated by its enable to form a summary bit and the `irq_o` output.

Top module: `rtc_regport`

## Requirements
- R1: A write with `data_port_i`=0 loads `bus_wdata_i` as the 8-bit index. The index is reset to 0 and keeps its value across any number of data-port accesses.
- R2: With index 0..9, a data write pulses `tod_wr_o` in the same cycle, with `tod_idx_o` equal to the index and `tod_wdata_o` equal to the write data. A data read returns `tod_rdata_i`.
- R3: Index 10 reads as {`uip_i`, stored bits 6:0}. A data write stores bits 6:0 on `ctrl_a_o`, and write bit 7 is ignored.
- R4: Index 11 is a plain 8-bit read/write register driven on `ctrl_b_o`, and it changes only on a data write to index 11. Its bit 4 enables update-end, bit 5 enables alarm and bit 6 enables periodic.
- R5: Index 13 reads as {`vrt_i`, 7'b0}, and data writes to it have no effect.
- R6: Index 12 reads as {summary, periodic flag, alarm flag, update-end flag, 4'b0}. A strobe (`uf_set_i`, `af_set_i`, `pf_set_i`) sets its flag on the next clock whatever the enables are.
- R7: The summary bit and `irq_o` are 1 exactly when some flag is set and its enable in index 11 is also set.
- R8: A data read of index 12 returns the pre-clear value and clears all flags on that clock. A strobe in the same cycle wins, so its flag stays set.
- R9: A data write to index 12 leaves the flags and `irq_o` unchanged.
- R10: Indexes 14..63 are 50 bytes of read/write storage that keep their contents until rewritten.
- R11: Indexes 64..255 read as 0, and data writes there alter nothing and do not pulse `tod_wr_o`.
- R12: After reset the index is 0, registers 10 and 11 are 0, all flags are 0 and `irq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_wr_i | input | 1 | Host write strobe |
| bus_rd_i | input | 1 | Host read strobe |
| data_port_i | input | 1 | 1 selects the data port, 0 the address port |
| bus_wdata_i | input | 8 | Host write data |
| bus_rdata_o | output | 8 | Read data for the current index |
| uip_i | input | 1 | Update-in-progress from the timekeeper |
| vrt_i | input | 1 | Battery-good sense |
| uf_set_i | input | 1 | Update-end event strobe |
| af_set_i | input | 1 | Alarm event strobe |
| pf_set_i | input | 1 | Periodic event strobe |
| tod_idx_o | output | 4 | Time/alarm register select |
| tod_wr_o | output | 1 | Time/alarm write strobe |
| tod_wdata_o | output | 8 | Time/alarm write data |
| tod_rdata_i | input | 8 | Time/alarm read data |
| ctrl_a_o | output | 7 | Divider select (6:4) and rate select (3:0) |
| ctrl_b_o | output | 8 | Mode and interrupt enable register |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
The bench targets a flag strobe that lands in the same cycle as a clearing read of the flag register. A design that lets the clear win drops that event, and the interrupt never comes back. It checks that a flag with its enable clear still reads as set while `irq_o` stays low. A design that gates setting by the enable would lose the event once the host enables it. It writes the read-only bits, the flag register and indexes at 64 and above, then reads the storage back. A design with a loose decode or a wrapped index would corrupt storage or pulse the counter bus. It also switches `uip_i` and `vrt_i` under a fixed index to catch read-only bits that are latched instead of passed through.

// File: rtl/rtc_regport_pkg.sv
package rtc_regport_pkg;
  typedef struct packed {
    logic pf;
    logic af;
    logic uf;
  } rtc_flags_t;
endpackage

// File: rtl/rtc_index_reg.sv
module rtc_index_reg #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] d_i,
  output logic [DW-1:0] idx_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     idx_o <= '0;
    else if (load_i) idx_o <= d_i;
  end
endmodule

// File: rtl/rtc_flag_reg.sv
module rtc_flag_reg
  import rtc_regport_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  rtc_flags_t set_i,
  input  logic       clr_i,
  input  rtc_flags_t en_i,
  output rtc_flags_t flags_o,
  output logic       irqf_o
);
  // set beats clear so an event arriving during the read is kept
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_o <= '0;
    else         flags_o <= (clr_i ? rtc_flags_t'('0) : flags_o) | set_i;
  end

  assign irqf_o = |(flags_o & en_i);
endmodule

// File: rtl/rtc_nvram.sv
module rtc_nvram #(
  parameter int unsigned DW    = 8,
  parameter int unsigned BASE  = 14,
  parameter int unsigned BYTES = 50
) (
  input  logic          clk_i,
  input  logic          wr_i,
  input  logic [DW-1:0] idx_i,
  input  logic [DW-1:0] wdata_i,
  output logic          hit_o,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned AW = $clog2(BYTES);
  localparam logic [DW-1:0] BASE_V = DW'(BASE);
  localparam logic [DW-1:0] LAST_V = DW'(BASE + BYTES - 1);

  logic [DW-1:0] mem_q [BYTES];
  logic [DW-1:0] off;

  assign off   = idx_i - BASE_V;
  assign hit_o = (idx_i >= BASE_V) && (idx_i <= LAST_V);

  // battery-backed contents: no reset
  always_ff @(posedge clk_i) begin
    if (wr_i && hit_o) mem_q[off[AW-1:0]] <= wdata_i;
  end

  assign rdata_o = hit_o ? mem_q[off[AW-1:0]] : '0;
endmodule

// File: rtl/rtc_regport.sv
module rtc_regport
  import rtc_regport_pkg::*;
#(
  parameter int unsigned DW        = 8,
  parameter int unsigned TOD_REGS  = 10,
  parameter int unsigned RAM_BYTES = 50
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        bus_wr_i,
  input  logic                        bus_rd_i,
  input  logic                        data_port_i,
  input  logic [DW-1:0]               bus_wdata_i,
  output logic [DW-1:0]               bus_rdata_o,
  input  logic                        uip_i,
  input  logic                        vrt_i,
  input  logic                        uf_set_i,
  input  logic                        af_set_i,
  input  logic                        pf_set_i,
  output logic [$clog2(TOD_REGS)-1:0] tod_idx_o,
  output logic                        tod_wr_o,
  output logic [DW-1:0]               tod_wdata_o,
  input  logic [DW-1:0]               tod_rdata_i,
  output logic [DW-2:0]               ctrl_a_o,
  output logic [DW-1:0]               ctrl_b_o,
  output logic                        irq_o
);
  localparam int unsigned TW = $clog2(TOD_REGS);
  localparam logic [DW-1:0] IDX_TOD_END = DW'(TOD_REGS);
  localparam logic [DW-1:0] IDX_A = DW'(TOD_REGS);
  localparam logic [DW-1:0] IDX_B = DW'(TOD_REGS + 1);
  localparam logic [DW-1:0] IDX_C = DW'(TOD_REGS + 2);
  localparam logic [DW-1:0] IDX_D = DW'(TOD_REGS + 3);
  localparam int unsigned RAM_BASE = TOD_REGS + 4;

  logic [DW-1:0] idx_q;
  logic          data_wr, data_rd;
  logic          sel_tod;
  logic [DW-2:0] ctrl_a_q;
  logic [DW-1:0] ctrl_b_q;
  rtc_flags_t    flags, flag_set, flag_en;
  logic          irqf;
  logic          ram_hit;
  logic [DW-1:0] ram_rdata;
  logic [DW-1:0] rdata;

  assign data_wr = bus_wr_i & data_port_i;
  assign data_rd = bus_rd_i & data_port_i;
  assign sel_tod = idx_q < IDX_TOD_END;

  rtc_index_reg #(.DW(DW)) u_index (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (bus_wr_i & ~data_port_i),
    .d_i    (bus_wdata_i),
    .idx_o  (idx_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_a_q <= '0;
      ctrl_b_q <= '0;
    end else if (data_wr) begin
      if (idx_q == IDX_A) ctrl_a_q <= bus_wdata_i[DW-2:0];
      if (idx_q == IDX_B) ctrl_b_q <= bus_wdata_i;
    end
  end

  assign flag_set = '{pf: pf_set_i, af: af_set_i, uf: uf_set_i};
  assign flag_en  = '{pf: ctrl_b_q[6], af: ctrl_b_q[5], uf: ctrl_b_q[4]};

  rtc_flag_reg u_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (flag_set),
    .clr_i   (data_rd && (idx_q == IDX_C)),
    .en_i    (flag_en),
    .flags_o (flags),
    .irqf_o  (irqf)
  );

  rtc_nvram #(.DW(DW), .BASE(RAM_BASE), .BYTES(RAM_BYTES)) u_ram (
    .clk_i   (clk_i),
    .wr_i    (data_wr),
    .idx_i   (idx_q),
    .wdata_i (bus_wdata_i),
    .hit_o   (ram_hit),
    .rdata_o (ram_rdata)
  );

  always_comb begin
    rdata = '0;
    if (sel_tod)              rdata = tod_rdata_i;
    else if (idx_q == IDX_A)  rdata = {uip_i, ctrl_a_q};
    else if (idx_q == IDX_B)  rdata = ctrl_b_q;
    else if (idx_q == IDX_C)  rdata = {irqf, flags.pf, flags.af, flags.uf, {(DW-4){1'b0}}};
    else if (idx_q == IDX_D)  rdata = {vrt_i, {(DW-1){1'b0}}};
    else if (ram_hit)         rdata = ram_rdata;
  end

  assign bus_rdata_o = rdata;
  assign tod_idx_o   = idx_q[TW-1:0];
  assign tod_wr_o    = data_wr & sel_tod;
  assign tod_wdata_o = bus_wdata_i;
  assign ctrl_a_o    = ctrl_a_q;
  assign ctrl_b_o    = ctrl_b_q;
  assign irq_o       = irqf;
endmodule

// File: rtl/rtc_regport_chk.sv
module rtc_regport_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       bus_wr_i,
  input logic       bus_rd_i,
  input logic       data_port_i,
  input logic [7:0] bus_rdata_o,
  input logic       uip_i,
  input logic       vrt_i,
  input logic       uf_set_i,
  input logic       af_set_i,
  input logic       pf_set_i,
  input logic       tod_wr_o,
  input logic [7:0] ctrl_b_o,
  input logic       irq_o,
  input logic [7:0] idx_q
);
  // R3
  uip_passthru_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx_q == 8'd10) |-> (bus_rdata_o[7] == uip_i));

  // R4
  ctrl_b_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_wr_i && data_port_i && idx_q == 8'd11) |=> $stable(ctrl_b_o));

  // R5
  status_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx_q == 8'd13) |-> (bus_rdata_o == {vrt_i, 7'b0}));

  // R7
  irq_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_b_o[6:4] == 3'b000) |-> !irq_o);

  // R8
  read_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rd_i && data_port_i && idx_q == 8'd12 && !uf_set_i && !af_set_i && !pf_set_i)
      |=> !irq_o);

  // R11
  out_of_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx_q >= 8'd64) |-> (bus_rdata_o == 8'd0 && !tod_wr_o));
endmodule

bind rtc_regport rtc_regport_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_wr_i    (bus_wr_i),
  .bus_rd_i    (bus_rd_i),
  .data_port_i (data_port_i),
  .bus_rdata_o (bus_rdata_o),
  .uip_i       (uip_i),
  .vrt_i       (vrt_i),
  .uf_set_i    (uf_set_i),
  .af_set_i    (af_set_i),
  .pf_set_i    (pf_set_i),
  .tod_wr_o    (tod_wr_o),
  .ctrl_b_o    (ctrl_b_o),
  .irq_o       (irq_o),
  .idx_q       (idx_q)
);

// File: tb/tb_rtc_regport.sv
`timescale 1ns/1ps
module tb_rtc_regport;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0, data_port = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       uip = 1'b0, vrt = 1'b0;
  logic       uf_set = 1'b0, af_set = 1'b0, pf_set = 1'b0;
  logic [3:0] tod_idx;
  logic       tod_wr;
  logic [7:0] tod_wdata;
  logic [7:0] tod_rdata = 8'h5A;
  logic [6:0] ctrl_a;
  logic [7:0] ctrl_b;
  logic       irq;

  always #10 clk = ~clk;

  rtc_regport dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(bus_wr), .bus_rd_i(bus_rd),
    .data_port_i(data_port), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .uip_i(uip), .vrt_i(vrt), .uf_set_i(uf_set), .af_set_i(af_set), .pf_set_i(pf_set),
    .tod_idx_o(tod_idx), .tod_wr_o(tod_wr), .tod_wdata_o(tod_wdata), .tod_rdata_i(tod_rdata),
    .ctrl_a_o(ctrl_a), .ctrl_b_o(ctrl_b), .irq_o(irq)
  );

  int checks = 0;
  int errors = 0;

  // reference model state
  int m_idx = 0, m_a = 0, m_b = 0, m_uf = 0, m_af = 0, m_pf = 0;
  int m_ram [50];
  bit m_ram_ok [50];

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int m_irq();
    return ((m_uf != 0 && m_b[4]) || (m_af != 0 && m_b[5]) || (m_pf != 0 && m_b[6])) ? 1 : 0;
  endfunction

  function automatic string m_tag();
    if (m_idx < 10)  return "R2";
    if (m_idx == 10) return "R3";
    if (m_idx == 11) return "R4";
    if (m_idx == 12) return "R6";
    if (m_idx == 13) return "R5";
    if (m_idx < 64)  return "R10";
    return "R11";
  endfunction

  function automatic int m_rdata();
    if (m_idx < 10)  return int'(tod_rdata);
    if (m_idx == 10) return (int'(uip) << 7) | m_a;
    if (m_idx == 11) return m_b;
    if (m_idx == 12) return (m_irq() << 7) | (m_pf << 6) | (m_af << 5) | (m_uf << 4);
    if (m_idx == 13) return int'(vrt) << 7;
    if (m_idx < 64)  return m_ram[m_idx - 14];
    return 0;
  endfunction

  // one bus cycle: drive at negedge, compare before posedge, update model at posedge
  task automatic step(bit wr, bit rd, bit dp, int wd, bit u = 0, bit a = 0, bit p = 0,
                      string xtag = "", int xexp = 0);
    @(negedge clk);
    bus_wr = wr; bus_rd = rd; data_port = dp; bus_wdata = wd[7:0];
    uf_set = u; af_set = a; pf_set = p;
    #8;
    if (!(m_idx >= 14 && m_idx < 64 && !m_ram_ok[m_idx - 14]))
      chk(m_tag(), int'(bus_rdata), m_rdata());
    chk("R7", int'(irq), m_irq());
    chk("R3", int'(ctrl_a), m_a);
    chk("R4", int'(ctrl_b), m_b);
    if (wr && dp && m_idx < 10) begin
      chk("R2", int'(tod_wr), 1);
      chk("R2", int'(tod_idx), m_idx);
      chk("R2", int'(tod_wdata), wd & 255);
    end else begin
      chk(m_idx >= 64 ? "R11" : "R2", int'(tod_wr), 0);
    end
    if (xtag != "") chk(xtag, int'(bus_rdata), xexp);
    @(posedge clk);
    if (rd && dp && m_idx == 12) begin m_uf = 0; m_af = 0; m_pf = 0; end
    if (u) m_uf = 1;
    if (a) m_af = 1;
    if (p) m_pf = 1;
    if (wr && !dp) m_idx = wd & 255;
    if (wr && dp) begin
      if (m_idx == 10) m_a = wd & 127;
      if (m_idx == 11) m_b = wd & 255;
      if (m_idx >= 14 && m_idx < 64) begin
        m_ram[m_idx - 14] = wd & 255;
        m_ram_ok[m_idx - 14] = 1'b1;
      end
    end
  endtask

  task automatic set_idx(int i);
    step(1, 0, 0, i);
  endtask

  task automatic wr_data(int d);
    step(1, 0, 1, d);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    foreach (m_ram_ok[i]) m_ram_ok[i] = 1'b0;
    foreach (m_ram[i]) m_ram[i] = 0;
    #25;
    // R12: reset state
    chk("R12", int'(irq), 0);
    chk("R12", int'(ctrl_a), 0);
    chk("R12", int'(ctrl_b), 0);
    chk("R12", int'(tod_idx), 0);
    chk("R12", int'(bus_rdata), int'(tod_rdata));
    @(negedge clk);
    rst_n = 1'b1;
    step(0, 0, 0, 0);

    // R2: time/alarm pass-through
    for (int i = 0; i < 10; i++) begin
      set_idx(i);
      tod_rdata = 8'(i * 17 + 1);
      wr_data(i * 3 + 40);
      step(0, 1, 1, 0);
    end

    // R3: divider/rate register, read-only top bit
    set_idx(10);
    wr_data(8'hFF);
    uip = 1'b1; step(0, 1, 1, 0, 0, 0, 0, "R3", 8'hFF);
    uip = 1'b0; step(0, 1, 1, 0, 0, 0, 0, "R3", 8'h7F);
    wr_data(8'h26);
    step(0, 1, 1, 0);

    // R4 / R1: mode register, index held over several accesses
    set_idx(11);
    wr_data(8'hA5);
    step(0, 1, 1, 0, 0, 0, 0, "R1", 8'hA5);
    step(0, 1, 1, 0, 0, 0, 0, "R1", 8'hA5);
    wr_data(8'h00);

    // R5: status register
    set_idx(13);
    vrt = 1'b1; step(0, 1, 1, 0, 0, 0, 0, "R5", 8'h80);
    wr_data(8'h7F);
    vrt = 1'b0; step(0, 1, 1, 0, 0, 0, 0, "R5", 8'h00);

    // R10: fill and read back storage
    for (int i = 14; i < 64; i++) begin
      set_idx(i);
      wr_data(i * 7 + 3);
    end
    for (int i = 14; i < 64; i++) begin
      set_idx(i);
      step(0, 1, 1, 0);
    end

    // R11: out-of-range indexes
    set_idx(64);  wr_data(8'hEE); step(0, 1, 1, 0, 0, 0, 0, "R11", 0);
    set_idx(78);  wr_data(8'hEE); step(0, 1, 1, 0, 0, 0, 0, "R11", 0);
    set_idx(255); wr_data(8'hEE); step(0, 1, 1, 0, 0, 0, 0, "R11", 0);
    set_idx(14);  step(0, 1, 1, 0, 0, 0, 0, "R11", (14 * 7 + 3) & 255);
    set_idx(63);  step(0, 1, 1, 0);

    // R6: flags set with enables off; irq stays low
    set_idx(11); wr_data(8'h00);
    step(0, 0, 0, 0, 1, 0, 0);
    set_idx(12);
    step(0, 0, 1, 0, 0, 0, 0, "R6", 8'h10);
    step(0, 0, 1, 0, 0, 1, 1);
    step(0, 0, 1, 0, 0, 0, 0, "R6", 8'h70);

    // R7: enabling one source raises irq and summary
    set_idx(11); wr_data(8'h20);
    set_idx(12);
    step(0, 0, 1, 0, 0, 0, 0, "R7", 8'hF0);

    // R8: read returns value then clears
    step(0, 1, 1, 0, 0, 0, 0, "R8", 8'hF0);
    step(0, 0, 1, 0, 0, 0, 0, "R8", 8'h00);

    // R8: strobe during the clearing read survives
    step(0, 0, 1, 0, 0, 1, 0);
    step(0, 1, 1, 0, 0, 1, 0, "R8", 8'hA0);
    step(0, 0, 1, 0, 0, 0, 0, "R8", 8'hA0);

    // R9: writes to the flag register are ignored
    wr_data(8'h00);
    step(0, 0, 1, 0, 0, 0, 0, "R9", 8'hA0);
    wr_data(8'hFF);
    step(0, 0, 1, 0, 0, 0, 0, "R9", 8'hA0);

    // R7: each enable against each flag
    set_idx(11); wr_data(8'h10);
    set_idx(12); step(0, 1, 1, 0);
    step(0, 0, 1, 0, 0, 0, 1);
    step(0, 0, 1, 0, 0, 0, 0, "R7", 8'h40);
    set_idx(11); wr_data(8'h40);
    set_idx(12); step(0, 0, 1, 0, 0, 0, 0, "R7", 8'hC0);
    step(0, 1, 1, 0);
    step(0, 0, 0, 0);

    summary();
    $finish;
  end
endmodule